// File: doc/BRIEF.md
# Skew-Tent-Map Keystream Generator

This block produces a pseudorandom keystream from a bank of chaotic cells. Each cell iterates a fixed-point skew tent map over the open interval (0,1). After each iteration a 61-bit linear feedback shift register perturbs the low bits of the new map state. Only the low bits of each cell's state are exposed, so most of the internal state stays hidden from anyone who sees the keystream. The cells' exposed bits are concatenated into one output word. With the default settings, four cells expose sixteen bits each and form a 64-bit word. A configuration with one cell and one exposed bit gives a single-bit stream, for example to mask a line-code header.

Each cell takes its own 189-bit key, which holds the control parameter, the initial map state and the register seed. A load pulse copies the key into the state. A step request starts one map iteration in all cells together. The division inside the map is done serially, one quotient bit per cycle. When the new word is ready the block raises a valid flag and holds the word until a consumer takes it with a ready pulse.

Top module: `stm_keystream`

## Requirements
- R1: After reset `outValid` is low and every cell holds state 1, map parameter 1 and register value 1, so each cell's slice of `outWord` reads 1.
- R2: A `loadKey` pulse copies the key into the cell state and clears `outValid`. The cell key layout is {seed[188:128], initial state[127:64], control parameter[63:0]}. After the load, each cell's slice of `outWord` shows the low bits of its initial state.
- R3: An iteration with state x and parameter g, both read as 64-bit integers scaled by 2^64, first computes q. If x ≤ g, q = floor(x·2^64/g). Otherwise q = floor((2^64−x)·2^64/(2^64−g)).
- R4: The new state is q XOR the low 8 bits of the register value held before the iteration. The register then advances once as a Fibonacci register: it shifts toward the MSB and takes in bit60^bit59^bit45^bit44 at bit 0. A zero seed is loaded as 1.
- R5: A quotient equal to 2^64 (when x = g) is clamped to all ones. A new state of 0 becomes 1. A zero initial state or a zero parameter is loaded as 1.
- R6: `outValid` rises exactly 65 clock edges after the edge that accepts a step request.
- R7: A step request is ignored while an iteration runs or while `outValid` is high. `outValid` and `outWord` hold until `outReady` is seen high, and `outValid` then drops on the next edge.
- R8: A `loadKey` pulse during an iteration aborts it. The aborted iteration then never raises `outValid` and leaves no trace in the state.
- R9: Cell i drives `outWord[i*OUT_W +: OUT_W]` with the low OUT_W bits of its state.
- R10: With one cell and OUT_W = 1, `outWord` is the least significant bit of the map state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadKey | input | 1 | Pulse: copy keys into cell state |
| keyIn | input | CELLS*189 | One 189-bit key per cell, cell 0 in the low bits |
| stepReq | input | 1 | Request one map iteration |
| outReady | input | 1 | Consumer takes the current word |
| outValid | output | 1 | A freshly computed word is available |
| outWord | output | CELLS*OUT_W | Concatenated low state bits of all cells |

## Verification
The bench builds two copies. The first uses the default four cells of sixteen bits, so one run covers the split around the map's peak, the equal-value clamp and a zero key on different cells at once. The second uses one cell with a one-bit output, which reaches the single-bit packing. Both keep the full 64-bit state width, so the serial divider runs its full 64-step length. That makes the exact valid latency, the hold of an unclaimed word, and an abort in the middle of a division all observable.

// File: rtl/stm_pkg.sv
package stm_pkg;
  localparam int STATE_W = 64;
  localparam int LFSR_W  = 61;
  localparam int MIX_W   = 8;
  localparam int KEY_W   = LFSR_W + 2 * STATE_W;
  localparam int TAP_A   = 60;
  localparam int TAP_B   = 59;
  localparam int TAP_C   = 45;
  localparam int TAP_D   = 44;

  typedef struct packed {
    logic load;
    logic start;
    logic iter;
    logic commit;
  } stmCtl_t;
endpackage

// File: rtl/stm_ctrl.sv
module stm_ctrl
  import stm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadKey,
  input  logic    stepReq,
  input  logic    outReady,
  output stmCtl_t ctl,
  output logic    busy,
  output logic    outValid
);
  localparam int CNT_W = $clog2(STATE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STATE_W);

  logic [CNT_W-1:0] bitCnt;
  logic             divDone;

  assign divDone = (bitCnt == LAST);

  always_comb begin
    ctl.load   = loadKey;
    ctl.start  = stepReq && !busy && !outValid && !loadKey;
    ctl.iter   = busy && !divDone && !loadKey;
    ctl.commit = busy && divDone && !loadKey;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      outValid <= 1'b0;
      bitCnt   <= '0;
    end else if (ctl.load) begin
      busy     <= 1'b0;
      outValid <= 1'b0;
      bitCnt   <= '0;
    end else if (ctl.start) begin
      busy   <= 1'b1;
      bitCnt <= '0;
    end else if (ctl.iter) begin
      bitCnt <= bitCnt + 1'b1;
    end else if (ctl.commit) begin
      busy     <= 1'b0;
      outValid <= 1'b1;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/stm_cell.sv
module stm_cell
  import stm_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stmCtl_t          ctl,
  input  logic [KEY_W-1:0] keyIn,
  output logic [OUT_W-1:0] cellOut
);
  localparam logic [STATE_W-1:0] ONE_S = {{(STATE_W-1){1'b0}}, 1'b1};
  localparam logic [LFSR_W-1:0]  ONE_L = {{(LFSR_W-1){1'b0}}, 1'b1};

  logic [STATE_W-1:0] mapX, mapG, divRem, divDen, divQuo;
  logic [LFSR_W-1:0]  lfsr;
  logic               satQ;

  logic [STATE_W-1:0] keyG, keyX, numC, denC, quoSat, mixed;
  logic [LFSR_W-1:0]  keyY, lfsrNext;
  logic [STATE_W:0]   shifted, diff;
  logic               lowSide, fits;

  assign keyG = keyIn[STATE_W-1:0];
  assign keyX = keyIn[2*STATE_W-1:STATE_W];
  assign keyY = keyIn[KEY_W-1:2*STATE_W];

  assign lowSide = (mapX <= mapG);
  assign numC    = lowSide ? mapX : (STATE_W'(0) - mapX);
  assign denC    = lowSide ? mapG : (STATE_W'(0) - mapG);

  assign shifted = {divRem, 1'b0};
  assign diff    = shifted - {1'b0, divDen};
  assign fits    = (shifted >= {1'b0, divDen});

  assign quoSat   = satQ ? {STATE_W{1'b1}} : divQuo;
  assign mixed    = quoSat ^ {{(STATE_W-MIX_W){1'b0}}, lfsr[MIX_W-1:0]};
  assign lfsrNext = {lfsr[LFSR_W-2:0], lfsr[TAP_A] ^ lfsr[TAP_B] ^ lfsr[TAP_C] ^ lfsr[TAP_D]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapX   <= ONE_S;
      mapG   <= ONE_S;
      lfsr   <= ONE_L;
      divRem <= '0;
      divDen <= ONE_S;
      divQuo <= '0;
      satQ   <= 1'b0;
    end else if (ctl.load) begin
      mapX <= (keyX == '0) ? ONE_S : keyX;
      mapG <= (keyG == '0) ? ONE_S : keyG;
      lfsr <= (keyY == '0) ? ONE_L : keyY;
    end else if (ctl.start) begin
      divRem <= numC;
      divDen <= denC;
      divQuo <= '0;
      satQ   <= (numC == denC);
    end else if (ctl.iter) begin
      divRem <= fits ? diff[STATE_W-1:0] : shifted[STATE_W-1:0];
      divQuo <= {divQuo[STATE_W-2:0], fits};
    end else if (ctl.commit) begin
      mapX <= (mixed == '0) ? ONE_S : mixed;
      lfsr <= lfsrNext;
    end
  end

  assign cellOut = mapX[OUT_W-1:0];
endmodule

// File: rtl/stm_keystream.sv
module stm_keystream
  import stm_pkg::*;
#(
  parameter int CELLS = 4,
  parameter int OUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   loadKey,
  input  logic [CELLS*KEY_W-1:0] keyIn,
  input  logic                   stepReq,
  input  logic                   outReady,
  output logic                   outValid,
  output logic [CELLS*OUT_W-1:0] outWord
);
  stmCtl_t ctl;
  logic    busy;

  stm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadKey(loadKey), .stepReq(stepReq),
    .outReady(outReady), .ctl(ctl), .busy(busy), .outValid(outValid)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    stm_cell #(.OUT_W(OUT_W)) u_cell (
      .clk(clk), .rstN(rstN), .ctl(ctl),
      .keyIn(keyIn[i*KEY_W +: KEY_W]),
      .cellOut(outWord[i*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/stm_keystream_chk.sv
module stm_keystream_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadKey,
  input logic              outReady,
  input logic              outValid,
  input logic              busy,
  input logic [WORD_W-1:0] outWord
);
  AST_LOAD_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    loadKey |=> !outValid); // R2
  AST_LOAD_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    loadKey |=> !busy); // R8
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !loadKey) |=> outValid); // R7
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !loadKey) |=> $stable(outWord)); // R7
  AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> !outValid); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !outValid); // R7
  AST_VALID_FROM_ITER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(busy)); // R6
endmodule

bind stm_keystream stm_keystream_chk #(.WORD_W(CELLS*OUT_W)) u_chk (
  .clk(clk), .rstN(rstN), .loadKey(loadKey), .outReady(outReady),
  .outValid(outValid), .busy(busy), .outWord(outWord)
);

// File: tb/stm_keystream_tb.sv
module stm_keystream_tb;
  localparam int KW = 189;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic          loadKey = 0, stepReq = 0, outReady = 0;
  logic [4*KW-1:0] keyIn = '0;
  logic          outValid;
  logic [63:0]   outWord;

  logic          bLoad = 0, bStep = 0, bReady = 0;
  logic [KW-1:0] bKey = '0;
  logic          bValid;
  logic [0:0]    bWord;

  stm_keystream u_dut (
    .clk(clk), .rstN(rstN), .loadKey(loadKey), .keyIn(keyIn), .stepReq(stepReq),
    .outReady(outReady), .outValid(outValid), .outWord(outWord)
  );

  stm_keystream #(.CELLS(1), .OUT_W(1)) u_dutBit (
    .clk(clk), .rstN(rstN), .loadKey(bLoad), .keyIn(bKey), .stepReq(bStep),
    .outReady(bReady), .outValid(bValid), .outWord(bWord)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] mX [5];
  logic [63:0] mG [5];
  logic [60:0] mL [5];

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  function automatic logic [60:0] lfsrNext(input logic [60:0] s);
    return {s[59:0], s[60] ^ s[59] ^ s[45] ^ s[44]};
  endfunction

  function automatic logic [63:0] mapNext(input logic [63:0] x, input logic [63:0] g, input logic [60:0] l);
    logic [127:0] num, den, q;
    logic [63:0]  r;
    if (x <= g) begin
      num = {64'd0, x};
      den = {64'd0, g};
    end else begin
      num = (128'd1 << 64) - {64'd0, x};
      den = (128'd1 << 64) - {64'd0, g};
    end
    q = (num << 64) / den;
    r = (q[127:64] != 0) ? 64'hFFFF_FFFF_FFFF_FFFF : q[63:0];
    r = r ^ {56'd0, l[7:0]};
    if (r == 0) r = 64'd1;
    return r;
  endfunction

  function automatic logic [63:0] expWord();
    logic [63:0] w;
    for (int i = 0; i < 4; i++) w[i*16 +: 16] = mX[i][15:0];
    return w;
  endfunction

  function automatic logic [KW-1:0] mkKey(input logic [60:0] y, input logic [63:0] x, input logic [63:0] g);
    return {y, x, g};
  endfunction

  task automatic modelLoad(input int i, input logic [KW-1:0] k);
    mG[i] = (k[63:0] == 0) ? 64'd1 : k[63:0];
    mX[i] = (k[127:64] == 0) ? 64'd1 : k[127:64];
    mL[i] = (k[188:128] == 0) ? 61'd1 : k[188:128];
  endtask

  task automatic loadMain(input logic [KW-1:0] k0, input logic [KW-1:0] k1,
                          input logic [KW-1:0] k2, input logic [KW-1:0] k3);
    @(negedge clk);
    keyIn = {k3, k2, k1, k0};
    loadKey = 1;
    @(posedge clk);
    @(negedge clk);
    loadKey = 0;
    modelLoad(0, k0); modelLoad(1, k1); modelLoad(2, k2); modelLoad(3, k3);
  endtask

  task automatic ackMain();
    @(negedge clk);
    outReady = 1;
    @(posedge clk);
    @(negedge clk);
    outReady = 0;
  endtask

  task automatic stepMain(input logic ack);
    int n;
    @(negedge clk);
    stepReq = 1;
    @(posedge clk);
    @(negedge clk);
    stepReq = 0;
    n = 0;
    while (!outValid && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == 65, "R6 valid latency", 64'(n), 64'd65);
    for (int i = 0; i < 4; i++) begin
      mX[i] = mapNext(mX[i], mG[i], mL[i]);
      mL[i] = lfsrNext(mL[i]);
    end
    check(outWord == expWord(), "R3 R4 R9 keystream word", outWord, expWord());
    if (ack) ackMain();
  endtask

  task automatic testReset();
    @(negedge clk);
    check(outValid == 0, "R1 valid low after reset", 64'(outValid), 64'd0);
    check(outWord == {4{16'h0001}}, "R1 reset state", outWord, {4{16'h0001}});
    check(bWord == 1'b1, "R1 single-bit reset state", 64'(bWord), 64'd1);
  endtask

  task automatic testLoad();
    loadMain(mkKey(61'h0_1234_5678_9ABC_DEF, 64'h4000_0000_0000_1234, 64'h8000_0000_0000_0000),
             mkKey(61'h1_ABCD_EF01_2345_678, 64'h9E37_79B9_7F4A_7C15, 64'h3333_3333_3333_3333),
             mkKey(61'h0_0F0F_0F0F_0F0F_0F0, 64'h6A09_E667_F3BC_C908, 64'h6A09_E667_F3BC_C908),
             mkKey(61'd0, 64'd0, 64'd0));
    check(outValid == 0, "R2 load clears valid", 64'(outValid), 64'd0);
    check(outWord == expWord(), "R2 R5 loaded initial state", outWord, expWord());
    check(outWord[63:48] == 16'h0001, "R5 zero initial state loads as 1", 64'(outWord[63:48]), 64'd1);
  endtask

  task automatic testSteps();
    for (int k = 0; k < 6; k++) stepMain(1'b1);
    check(outValid == 0, "R7 ready drops valid", 64'(outValid), 64'd0);
  endtask

  task automatic testEqualClamp();
    loadMain(mkKey(61'h55, 64'h2000_0000_0000_0000, 64'h2000_0000_0000_0000),
             mkKey(61'h0, 64'hC000_0000_0000_0000, 64'hC000_0000_0000_0000),
             mkKey(61'h7F, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF),
             mkKey(61'h3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1));
    stepMain(1'b1);
    check(outWord[15:0] == (16'hFFFF ^ 16'h0055), "R5 equal values clamp to all ones", 64'(outWord[15:0]), 64'(16'hFFFF ^ 16'h0055));
    check(outWord[31:16] == 16'hFFFE, "R4 zero seed becomes 1", 64'(outWord[31:16]), 64'hFFFE);
    for (int k = 0; k < 3; k++) stepMain(1'b1);
  endtask

  task automatic testHold();
    logic [63:0] held;
    stepMain(1'b0);
    held = outWord;
    @(negedge clk);
    stepReq = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    stepReq = 0;
    repeat (80) @(negedge clk);
    check(outValid == 1, "R7 valid holds without ready", 64'(outValid), 64'd1);
    check(outWord == held, "R7 step ignored while word pending", outWord, held);
    ackMain();
    check(outValid == 0, "R7 valid drops after ready", 64'(outValid), 64'd0);
    stepMain(1'b1);
  endtask

  task automatic testAbort();
    @(negedge clk);
    stepReq = 1;
    @(posedge clk);
    @(negedge clk);
    stepReq = 0;
    repeat (10) @(negedge clk);
    loadMain(mkKey(61'h1F_2E3D, 64'h5555_0000_AAAA_0001, 64'h7000_0000_0000_0000),
             mkKey(61'h99, 64'h1111_2222_3333_4444, 64'hA000_0000_0000_0000),
             mkKey(61'h42, 64'hDEAD_BEEF_0000_F00D, 64'h4000_0000_0000_0000),
             mkKey(61'h7, 64'h0000_0000_0000_0100, 64'h0000_0001_0000_0000));
    repeat (80) @(negedge clk);
    check(outValid == 0, "R8 aborted iteration never completes", 64'(outValid), 64'd0);
    check(outWord == expWord(), "R8 state is the new key", outWord, expWord());
    stepMain(1'b1);
    stepMain(1'b1);
  endtask

  task automatic testBit();
    int n;
    logic [KW-1:0] k;
    k = mkKey(61'h0_ABCD_1234, 64'h3C6E_F372_FE94_F82B, 64'hA54F_F53A_5F1D_36F1);
    @(negedge clk);
    bKey = k;
    bLoad = 1;
    @(posedge clk);
    @(negedge clk);
    bLoad = 0;
    modelLoad(4, k);
    check(bWord == mX[4][0], "R10 single-bit loaded state", 64'(bWord), 64'(mX[4][0]));
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      bStep = 1;
      @(posedge clk);
      @(negedge clk);
      bStep = 0;
      n = 0;
      while (!bValid && n < 200) begin
        @(negedge clk);
        n++;
      end
      mX[4] = mapNext(mX[4], mG[4], mL[4]);
      mL[4] = lfsrNext(mL[4]);
      check(n == 65, "R6 single-bit latency", 64'(n), 64'd65);
      check(bWord == mX[4][0], "R10 single-bit keystream", 64'(bWord), 64'(mX[4][0]));
      @(negedge clk);
      bReady = 1;
      @(posedge clk);
      @(negedge clk);
      bReady = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testLoad();
    testSteps();
    testEqualClamp();
    testHold();
    testAbort();
    testBit();
    finishRun();
  end
endmodule